// File: doc/BRIEF.md
# Branch Rename Checkpoint Manager

This block keeps the live register rename map of an out-of-order core, together with a few saved copies of that map, one copy for each branch that has not yet resolved. When the front end announces a branch and a copy slot is free, the block stores the current map into that slot. When no slot is free, the branch is held as the one branch waiting for a slot. The front end sees this through `br_stall` and must stop renaming until the stall clears.

Slots are used in program order as a ring. A branch that resolves as correctly predicted gives its slot back. A slot becomes usable again once every older slot has also been given back. The waiting branch can take that slot in the same cycle. A misprediction copies the branch's saved map back into the live map. The same event drops that slot, every younger slot and the waiting branch.

Two resolution ports let two branches resolve in one cycle. The map has one rename write port and one combinational read port.

Top module: `br_ckpt_mgr`

## Requirements
- R1: After reset, map entry i reads physical register i, no branch is waiting (`br_stall` low) and all 4 slots are free.
- R2: `rd_preg` shows the live entry addressed by `rd_arch`. A rename write (`ren_we`) is visible from the cycle after its edge.
- R3: Up to 4 unresolved branches each get a slot without stalling. The saved copy is the map as it stands after that cycle's rename write.
- R4: A branch that finds all 4 slots taken raises `br_stall` from the next cycle. While `br_stall` is high, further `br_alloc` requests are ignored.
- R5: A correct resolution frees a slot only once all older slots are free. A branch waiting for a slot takes it in that same cycle, and `br_stall` drops after that edge.
- R6: A correct resolution of the waiting branch clears `br_stall` and takes no slot.
- R7: A misprediction (`res_mispredict`=1) of a branch holding a slot overwrites every live map entry with that slot's copy. The result is visible after the edge.
- R8: A misprediction drops the mispredicted branch's slot, all younger slots and any waiting branch. Those slots become free, and later resolutions naming the dropped tags have no effect.
- R9: When several resolutions arrive in one cycle, a misprediction takes precedence. A correct resolution of an older branch still frees its slot. A correct resolution of the same or a younger branch has no effect. Of two mispredictions, the older one is applied.
- R10: In a cycle that restores the map, the rename write and any `br_alloc` are ignored.
- R11: A misprediction of the waiting branch clears `br_stall` and leaves the live map unchanged.
- R12: A resolution whose tag matches no in-flight branch changes neither the map nor the slot usage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_we | input | 1 | Rename write enable |
| ren_arch | input | 5 | Architectural register being renamed |
| ren_preg | input | 6 | New physical register for `ren_arch` |
| rd_arch | input | 5 | Map read address |
| rd_preg | output | 6 | Live map entry at `rd_arch` |
| br_alloc | input | 1 | A branch is decoded this cycle |
| br_tag | input | 3 | Tag of the decoded branch |
| br_stall | output | 1 | A branch is waiting for a slot; renaming must pause |
| res_valid | input | 2 | Per-port resolution valid |
| res_tag | input | 6 | Per-port branch tag, port p at bits [3p+2:3p] |
| res_mispredict | input | 2 | Per-port: 1 mispredicted, 0 correct |

## Verification
The assertions assume the following about the inputs:
- Tags are unique among in-flight branches.
- Each branch resolves at most once.
- No rename write arrives while `br_stall` is high, so a waiting branch's map is still the live one when it receives a slot.

The stimulus keeps to these assumptions. It reuses a tag only after that branch has resolved or been dropped, and it renames only while `br_stall` is low. Resolutions naming dropped or unknown tags are sent on purpose, because the block must ignore them.

// File: rtl/br_ckpt_pkg.sv
package br_ckpt_pkg;
  localparam int unsigned CKPT_SLOTS = 4;   // power of two
  localparam int unsigned ARCH_REGS  = 32;
  localparam int unsigned PREG_BITS  = 6;
  localparam int unsigned TAG_BITS   = 3;
  localparam int unsigned RES_PORTS  = 2;
endpackage

// File: rtl/br_ckpt_store.sv
module br_ckpt_store #(
  parameter int unsigned NSLOT = 4,
  parameter int unsigned NARCH = 32,
  parameter int unsigned PW    = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ren_we,
  input  logic [$clog2(NARCH)-1:0]      ren_arch,
  input  logic [PW-1:0]                 ren_preg,
  input  logic [$clog2(NARCH)-1:0]      rd_arch,
  output logic [PW-1:0]                 rd_preg,
  input  logic                          snap_en,
  input  logic [$clog2(NSLOT)-1:0]      snap_idx,
  input  logic                          restore_en,
  input  logic [$clog2(NSLOT)-1:0]      restore_idx,
  output logic [NARCH*PW-1:0]           live_flat,
  output logic [NSLOT*NARCH*PW-1:0]     ckpt_flat
);
  localparam int unsigned AW = $clog2(NARCH);
  localparam int unsigned SW = $clog2(NSLOT);
  localparam int unsigned MW = NARCH * PW;

  logic [PW-1:0] live_q [NARCH];
  logic [PW-1:0] live_d [NARCH];

  // next live map: restore wins over the rename write
  always_comb begin
    for (int a = 0; a < NARCH; a++) begin
      if (restore_en)
        live_d[a] = ckpt_flat[int'(restore_idx)*MW + a*PW +: PW];
      else if (ren_we && (ren_arch == AW'(a)))
        live_d[a] = ren_preg;
      else
        live_d[a] = live_q[a];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < NARCH; a++) live_q[a] <= PW'(a);
    end else begin
      live_q <= live_d;
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic [PW-1:0] copy_q [NARCH];
    always_ff @(posedge clk) begin
      if (snap_en && (snap_idx == SW'(s))) copy_q <= live_d;
    end
    for (genvar a = 0; a < NARCH; a++) begin : g_ent
      assign ckpt_flat[s*MW + a*PW +: PW] = copy_q[a];
    end
  end

  for (genvar a = 0; a < NARCH; a++) begin : g_live
    assign live_flat[a*PW +: PW] = live_q[a];
  end

  assign rd_preg = live_q[rd_arch];
endmodule

// File: rtl/br_ckpt_ctrl.sv
module br_ckpt_ctrl #(
  parameter int unsigned NSLOT = 4,
  parameter int unsigned TW    = 3,
  parameter int unsigned NRES  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         br_alloc,
  input  logic [TW-1:0]                br_tag,
  input  logic [NRES-1:0]              res_valid,
  input  logic [NRES*TW-1:0]           res_tag,
  input  logic [NRES-1:0]              res_mispredict,
  output logic                         br_stall,
  output logic                         snap_en,
  output logic [$clog2(NSLOT)-1:0]     snap_idx,
  output logic                         restore_en,
  output logic [$clog2(NSLOT)-1:0]     restore_idx,
  output logic [$clog2(NSLOT+1)-1:0]   occ_cnt
);
  localparam int unsigned SW = $clog2(NSLOT);
  localparam int unsigned CW = $clog2(NSLOT+1);

  logic [SW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [NSLOT-1:0] vld_q, vld_d;
  logic [TW-1:0] tag_q [NSLOT];
  logic wait_q, wait_d;
  logic [TW-1:0] wtag_q, wtag_d;

  logic [SW-1:0] age [NSLOT];
  logic [NSLOT-1:0] occ_v;

  logic          mis_slot, mis_any, wait_done, run, take;
  logic [SW-1:0] mis_idx, mis_age, tail_a, idx;
  logic [CW-1:0] cnt_a, cnt_b, pops;
  logic [TW-1:0] tg, new_tag;

  for (genvar g = 0; g < NSLOT; g++) begin : g_age
    assign age[g]   = SW'(g) - head_q;
    assign occ_v[g] = (CW'(age[g]) < cnt_q);
  end

  always_comb begin
    vld_d     = vld_q;
    mis_slot  = 1'b0;
    mis_idx   = '0;
    mis_age   = '0;
    mis_any   = 1'b0;
    wait_done = 1'b0;
    tg        = '0;
    // match resolutions against the waiting branch and the occupied slots
    for (int p = 0; p < NRES; p++) begin
      tg = res_tag[p*TW +: TW];
      if (res_valid[p]) begin
        if (wait_q && (wtag_q == tg)) begin
          if (res_mispredict[p]) mis_any = 1'b1;
          else                   wait_done = 1'b1;
        end
        for (int i = 0; i < NSLOT; i++) begin
          if (occ_v[i] && vld_q[i] && (tag_q[i] == tg)) begin
            if (res_mispredict[p]) begin
              if (!mis_slot || (age[i] < mis_age)) begin
                mis_slot = 1'b1;
                mis_idx  = SW'(i);
                mis_age  = age[i];
              end
            end else begin
              vld_d[i] = 1'b0;
            end
          end
        end
      end
    end
    if (mis_slot) mis_any = 1'b1;

    // a misprediction cuts the ring back to the mispredicted slot
    cnt_a  = mis_slot ? CW'(mis_age) : cnt_q;
    tail_a = mis_slot ? mis_idx : tail_q;

    // reclaim released slots from the oldest end
    pops = '0;
    run  = 1'b1;
    idx  = head_q;
    for (int k = 0; k < NSLOT; k++) begin
      idx = head_q + SW'(k);
      if (run && (CW'(k) < cnt_a) && !vld_d[idx]) pops = pops + CW'(1);
      else                                          run  = 1'b0;
    end
    head_d = head_q + SW'(pops);
    cnt_b  = cnt_a - pops;

    wait_d  = wait_q;
    wtag_d  = wtag_q;
    take    = 1'b0;
    new_tag = br_tag;
    if (mis_any) begin
      wait_d = 1'b0;
    end else if (wait_q) begin
      if (wait_done) begin
        wait_d = 1'b0;
      end else if (cnt_b < CW'(NSLOT)) begin
        take    = 1'b1;
        new_tag = wtag_q;
        wait_d  = 1'b0;
      end
    end else if (br_alloc) begin
      if (cnt_b < CW'(NSLOT)) begin
        take = 1'b1;
      end else begin
        wait_d = 1'b1;
        wtag_d = br_tag;
      end
    end

    if (take) begin
      vld_d[tail_a] = 1'b1;
      tail_d        = tail_a + SW'(1);
      cnt_d         = cnt_b + CW'(1);
    end else begin
      tail_d = tail_a;
      cnt_d  = cnt_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      vld_q  <= '0;
      wait_q <= 1'b0;
      wtag_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
      vld_q  <= vld_d;
      wait_q <= wait_d;
      wtag_q <= wtag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) tag_q[i] <= '0;
    end else if (take) begin
      tag_q[tail_a] <= new_tag;
    end
  end

  assign br_stall    = wait_q;
  assign snap_en     = take;
  assign snap_idx    = tail_a;
  assign restore_en  = mis_slot;
  assign restore_idx = mis_idx;
  assign occ_cnt     = cnt_q;
endmodule

// File: rtl/br_ckpt_mgr.sv
module br_ckpt_mgr
  import br_ckpt_pkg::*;
#(
  parameter int unsigned NSLOT = CKPT_SLOTS,
  parameter int unsigned NARCH = ARCH_REGS,
  parameter int unsigned PW    = PREG_BITS,
  parameter int unsigned TW    = TAG_BITS,
  parameter int unsigned NRES  = RES_PORTS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ren_we,
  input  logic [$clog2(NARCH)-1:0]  ren_arch,
  input  logic [PW-1:0]             ren_preg,
  input  logic [$clog2(NARCH)-1:0]  rd_arch,
  output logic [PW-1:0]             rd_preg,
  input  logic                      br_alloc,
  input  logic [TW-1:0]             br_tag,
  output logic                      br_stall,
  input  logic [NRES-1:0]           res_valid,
  input  logic [NRES*TW-1:0]        res_tag,
  input  logic [NRES-1:0]           res_mispredict
);
  localparam int unsigned SW = $clog2(NSLOT);
  localparam int unsigned CW = $clog2(NSLOT+1);

  logic                      snap_en, restore_en;
  logic [SW-1:0]             snap_idx, restore_idx;
  logic [CW-1:0]             occ_cnt;
  logic [NARCH*PW-1:0]       live_flat;
  logic [NSLOT*NARCH*PW-1:0] ckpt_flat;

  br_ckpt_ctrl #(.NSLOT(NSLOT), .TW(TW), .NRES(NRES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .br_alloc(br_alloc), .br_tag(br_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_mispredict(res_mispredict),
    .br_stall(br_stall),
    .snap_en(snap_en), .snap_idx(snap_idx),
    .restore_en(restore_en), .restore_idx(restore_idx),
    .occ_cnt(occ_cnt)
  );

  br_ckpt_store #(.NSLOT(NSLOT), .NARCH(NARCH), .PW(PW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ren_we(ren_we), .ren_arch(ren_arch), .ren_preg(ren_preg),
    .rd_arch(rd_arch), .rd_preg(rd_preg),
    .snap_en(snap_en), .snap_idx(snap_idx),
    .restore_en(restore_en), .restore_idx(restore_idx),
    .live_flat(live_flat), .ckpt_flat(ckpt_flat)
  );
endmodule

// File: rtl/br_ckpt_chk.sv
module br_ckpt_chk #(
  parameter int unsigned NSLOT = 4,
  parameter int unsigned NARCH = 32,
  parameter int unsigned PW    = 6,
  parameter int unsigned NRES  = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        ren_we,
  input logic                        br_alloc,
  input logic                        br_stall,
  input logic [NRES-1:0]             res_valid,
  input logic                        snap_en,
  input logic                        restore_en,
  input logic [$clog2(NSLOT)-1:0]    restore_idx,
  input logic [$clog2(NSLOT+1)-1:0]  occ_cnt,
  input logic [NARCH*PW-1:0]         live_flat,
  input logic [NSLOT*NARCH*PW-1:0]   ckpt_flat
);
  localparam int unsigned MW = NARCH * PW;
  localparam int unsigned CW = $clog2(NSLOT+1);

  logic [MW-1:0] sel_copy;
  assign sel_copy = ckpt_flat[int'(restore_idx)*MW +: MW];

  p_map_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ren_we && !restore_en) |=> $stable(live_flat));

  p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ_cnt <= CW'(NSLOT));

  p_snap_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_en && (res_valid == '0)) |-> (occ_cnt < CW'(NSLOT)));

  p_full_stalls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_alloc && !br_stall && (occ_cnt == CW'(NSLOT)) && (res_valid == '0)) |=> br_stall);

  p_stall_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_stall && (res_valid == '0)) |=> br_stall);

  p_restore_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |=> (live_flat == $past(sel_copy)));

  p_restore_drops_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |=> !br_stall);

  p_restore_no_snap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |-> !snap_en);
endmodule

bind br_ckpt_mgr br_ckpt_chk #(.NSLOT(NSLOT), .NARCH(NARCH), .PW(PW), .NRES(NRES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ren_we(ren_we), .br_alloc(br_alloc), .br_stall(br_stall),
  .res_valid(res_valid), .snap_en(snap_en), .restore_en(restore_en),
  .restore_idx(restore_idx), .occ_cnt(occ_cnt), .live_flat(live_flat), .ckpt_flat(ckpt_flat)
);

// File: tb/sim_br_ckpt_mgr.sv
`timescale 1ns/10ps
module sim_br_ckpt_mgr;
  localparam int NARCH = 32;
  localparam int PW    = 6;
  localparam int TW    = 3;
  localparam int NRES  = 2;

  logic clk, rst_n;
  logic ren_we, br_alloc, br_stall;
  logic [4:0] ren_arch, rd_arch;
  logic [PW-1:0] ren_preg, rd_preg;
  logic [TW-1:0] br_tag;
  logic [NRES-1:0] res_valid, res_mispredict;
  logic [NRES*TW-1:0] res_tag;

  br_ckpt_mgr u0 (
    .clk(clk), .rst_n(rst_n), .ren_we(ren_we), .ren_arch(ren_arch), .ren_preg(ren_preg),
    .rd_arch(rd_arch), .rd_preg(rd_preg), .br_alloc(br_alloc), .br_tag(br_tag),
    .br_stall(br_stall), .res_valid(res_valid), .res_tag(res_tag), .res_mispredict(res_mispredict)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct { int kind; int arch; int exp; string req; } item_t;
  item_t sb_q[$];
  event  chk_ev;
  bit    mon_busy;
  int    n_run, n_fail;
  int    ref_map [NARCH];
  int    snap [8][NARCH];

  // monitor: pops expected items and compares against the ports
  initial begin
    rd_arch = '0;
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        int act;
        it = sb_q.pop_front();
        if (it.kind == 0) begin
          rd_arch = 5'(it.arch);
          #0.05;
          act = int'(rd_preg);
        end else begin
          act = int'(br_stall);
        end
        n_run++;
        if (act != it.exp) begin
          n_fail++;
          if (it.kind == 0)
            $display("FAIL %s: map[%0d] actual %0d expected %0d", it.req, it.arch, act, it.exp);
          else
            $display("FAIL %s: br_stall actual %0d expected %0d", it.req, act, it.exp);
        end
      end
      mon_busy = 1'b0;
    end
  end

  task automatic exp_map(int a, int v, string r);
    item_t it;
    it.kind = 0; it.arch = a; it.exp = v; it.req = r;
    sb_q.push_back(it);
  endtask

  task automatic exp_all(string r);
    for (int a = 0; a < NARCH; a++) exp_map(a, ref_map[a], r);
  endtask

  task automatic exp_stall(int v, string r);
    item_t it;
    it.kind = 1; it.arch = 0; it.exp = v; it.req = r;
    sb_q.push_back(it);
  endtask

  task automatic flush();
    mon_busy = 1'b1;
    -> chk_ev;
    wait (mon_busy == 1'b0);
    #0.1;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    ren_we = 0; br_alloc = 0; res_valid = '0; res_mispredict = '0;
  endtask

  task automatic take_snap(int t);
    for (int a = 0; a < NARCH; a++) snap[t][a] = ref_map[a];
  endtask

  task automatic restore_from(int t);
    for (int a = 0; a < NARCH; a++) ref_map[a] = snap[t][a];
  endtask

  task automatic ren(int a, int p);
    ren_we = 1; ren_arch = 5'(a); ren_preg = PW'(p);
    step();
    ref_map[a] = p;
  endtask

  task automatic alloc(int t);
    br_alloc = 1; br_tag = TW'(t);
    step();
  endtask

  task automatic set_res(int port, int t, bit mis);
    res_valid[port] = 1'b1;
    res_mispredict[port] = mis;
    res_tag[port*TW +: TW] = TW'(t);
  endtask

  task automatic res1(int port, int t, bit mis);
    set_res(port, t, mis);
    step();
  endtask

  bit done;
  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    done = 0; n_run = 0; n_fail = 0;
    rst_n = 0; ren_we = 0; ren_arch = '0; ren_preg = '0; br_alloc = 0; br_tag = '0;
    res_valid = '0; res_tag = '0; res_mispredict = '0;
    for (int a = 0; a < NARCH; a++) ref_map[a] = a;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    exp_all("R1"); exp_stall(0, "R1"); flush();

    ren(3, 40); exp_map(3, 40, "R2"); exp_map(4, 4, "R2"); flush();

    // fill the four slots
    alloc(0); take_snap(0);
    ren(3, 41);
    ren_we = 1; ren_arch = 5; ren_preg = 50; br_alloc = 1; br_tag = 1;
    step(); ref_map[5] = 50; take_snap(1);
    ren(3, 42);
    alloc(2); take_snap(2);
    alloc(3); take_snap(3);
    exp_stall(0, "R3"); flush();
    alloc(4); exp_stall(1, "R4"); flush();
    alloc(5); exp_stall(1, "R4"); flush();

    // release out of order, then the oldest: handover
    res1(0, 1, 0); exp_stall(1, "R5"); flush();
    res1(0, 0, 0); take_snap(4); exp_stall(0, "R5"); flush();

    // misprediction with a rename and an alloc in the same cycle
    ren(7, 60);
    set_res(0, 3, 1);
    ren_we = 1; ren_arch = 9; ren_preg = 33; br_alloc = 1; br_tag = 6;
    step(); restore_from(3);
    exp_all("R7"); exp_map(9, ref_map[9], "R10"); exp_stall(0, "R8"); flush();

    ren(9, 20);
    res1(1, 4, 1); exp_map(9, 20, "R8"); exp_all("R8"); flush();
    res1(0, 6, 1); exp_all("R10"); flush();

    alloc(6); take_snap(6);
    ren(11, 12);
    alloc(7); take_snap(7);
    ren(12, 13);
    alloc(0); take_snap(0);
    exp_stall(0, "R8"); flush();
    alloc(1); exp_stall(1, "R8"); flush();

    res1(0, 1, 1); exp_stall(0, "R11"); exp_all("R11"); flush();

    alloc(1); exp_stall(1, "R6"); flush();
    res1(0, 1, 0); exp_stall(0, "R6"); flush();
    alloc(5); exp_stall(1, "R6"); flush();
    res1(1, 5, 0); exp_stall(0, "R6"); flush();

    // older correct on port 0 with younger misprediction on port 1
    set_res(0, 2, 0); set_res(1, 7, 1);
    step(); restore_from(7); exp_all("R9"); flush();
    ren(13, 14); alloc(1); take_snap(1);
    ren(14, 15); alloc(3); take_snap(3);
    ren(15, 16); alloc(4); take_snap(4);
    exp_stall(0, "R9"); flush();
    ren(16, 17); alloc(5); exp_stall(1, "R9"); flush();
    res1(0, 5, 0);

    // misprediction and correct on the same tag
    set_res(0, 4, 1); set_res(1, 4, 0);
    step(); restore_from(4); exp_all("R9"); flush();
    alloc(5); take_snap(5); exp_stall(0, "R9"); flush();
    alloc(2); exp_stall(1, "R9"); flush();

    // two mispredictions: the older one is applied
    set_res(0, 3, 1); set_res(1, 1, 1);
    step(); restore_from(1); exp_all("R9"); exp_stall(0, "R9"); flush();

    // unknown tags
    res1(0, 7, 1); exp_all("R12"); flush();
    res1(1, 2, 0); exp_stall(0, "R12"); flush();
    alloc(1); alloc(2); alloc(3); exp_stall(0, "R12"); flush();
    alloc(4); exp_stall(1, "R12"); flush();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule